// File: doc/BRIEF.md
# Address Control and Mapping Unit

This block holds the 8-bit address control register of a microcontroller core and turns its fields into the signals the core needs. These are the chip selects for the two 32 KB internal ROM blocks, the stack address, the addressing-mode code and the high program-counter byte. It also drives the breakpoint-enable flag, the boot-source choice and a self-reset request. The register can be read freely. A write changes it only inside a short timed-access window, which software opens by writing the byte pair AAh, 55h to a separate unlock address.

The boot-source choice is captured only while a reset is applied. A later write to the boot bit therefore changes the boot path only at the next reset. The one exception is a change from 0 to 1 while the external-access pin is high, which asks for a reset at once. The kind of reset matters: power-on clears the boot bit, and a warm reset keeps it.

Top module: `addr_ctl_unit`

## Requirements
- R1: While `sfr_addr` is 9Dh, `sfr_rdata` shows the control register in the same cycle, whether or not a window is open. At any other address `sfr_rdata` is 00h.
- R2: A write to 9Dh is accepted only if it lands 1, 2 or 3 cycles after a write of 55h to the unlock address C7h, and only if that 55h write directly followed a write of AAh to C7h, with no SFR write of any other kind in between. The first accepted write closes the window. Every other write to 9Dh is ignored.
- R3: Power-on reset loads C0h. Warm reset loads C0h with bit 3 kept. Bits 7:6 always read 1, whatever value is written.
- R4: `rom_lo_sel` is high for `fetch_addr` 000000h–007FFFh when bit 5 is 0, and for FF0000h–FF7FFFh when bit 5 is 1.
- R5: `rom_hi_sel` is high exactly for `fetch_addr` FF8000h–FFFFFFh, for either value of bit 5.
- R6: `bkpt_en` equals bit 4.
- R7: `boot_internal` is captured during reset. Power-on captures `ea_pin`. Warm reset captures `ea_pin` AND NOT bit 3. Outside reset it holds, so a write to bit 3 has no effect on it until the next reset.
- R8: `self_rst_req` is high for one cycle, in the cycle after an accepted write that sets bit 3 from 0 to 1 while `ea_pin` is high. It stays low if bit 3 was already 1 or if `ea_pin` is low.
- R9: `stack_addr` is {00b, `sp`} when bit 2 is 0, and {`esp_lo`[1:0], `sp`} when bit 2 is 1.
- R10: `addr_mode` is 0 for bits 1:0 = 00 (16-bit), 1 for 01 (paged) and 2 for 1x (contiguous).
- R11: In 16-bit mode `pc_hi` is 00h. In paged mode, `pc_hi` takes `ap` in the cycle after a `page_load` strobe. In contiguous mode `page_load` has no effect and `pc_hi` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| warm_rst_n | input | 1 | Warm reset, active low, synchronous |
| sfr_addr | input | 8 | Special-function register address |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data |
| ea_pin | input | 1 | External-access pin level |
| fetch_addr | input | 24 | Program address to decode |
| sp | input | 8 | Stack pointer |
| esp_lo | input | 2 | Low bits of the extended stack pointer |
| ap | input | 8 | Address page value |
| page_load | input | 1 | Strobe that loads the page into the high PC byte |
| rom_lo_sel | output | 1 | Lower internal ROM block selected |
| rom_hi_sel | output | 1 | Upper internal ROM block selected |
| boot_internal | output | 1 | Reset entry is internal ROM |
| stack_addr | output | 10 | Stack memory address |
| addr_mode | output | 2 | Addressing mode code |
| pc_hi | output | 8 | High program-counter byte |
| bkpt_en | output | 1 | Breakpoint mode enabled |
| self_rst_req | output | 1 | One-cycle self-reset request |

## Verification
The case hardest to reach from the ports is a write that lands at the exact edge of the timed-access window. Reaching it needs a full unlock sequence followed by a precisely counted gap. The stimulus sweeps the gap from zero to four idle cycles and also interrupts the key sequence, so it probes both the accepting and the rejecting side of each boundary. The self-reset pulse and the boot-capture behaviour depend on the bit 3 history and on the pin level. They are reached by a fixed chain of protected writes and warm and power-on resets, with the pin set high or low at each step.

// File: rtl/addr_ctl_pkg.sv
`timescale 1ns/1ps
package addr_ctl_pkg;

   typedef enum logic [1:0] {
      AMODE_16     = 2'd0,
      AMODE_PAGED  = 2'd1,
      AMODE_CONTIG = 2'd2
   } amode_e;

   localparam int CTL_W       = 8;
   localparam int BIT_ROM_ALT = 5;
   localparam int BIT_BKPT    = 4;
   localparam int BIT_BOOT    = 3;
   localparam int BIT_STK     = 2;

   function automatic amode_e decode_amode(input logic [1:0] fld);
      if (fld[1])      return AMODE_CONTIG;
      else if (fld[0]) return AMODE_PAGED;
      return AMODE_16;
   endfunction

endpackage

// File: rtl/acu_timed_gate.sv
`timescale 1ns/1ps
module acu_timed_gate #(
   parameter int               SFR_AW      = 8,
   parameter logic [SFR_AW-1:0] UNLOCK_ADDR = 8'hC7,
   parameter logic [7:0]       KEY_A       = 8'hAA,
   parameter logic [7:0]       KEY_B       = 8'h55,
   parameter int               WINDOW_CYC  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sfr_wr,
   input  logic [SFR_AW-1:0] sfr_addr,
   input  logic [7:0]        sfr_wdata,
   input  logic              prot_hit,
   output logic              win_open
);
   localparam int CNT_W = $clog2(WINDOW_CYC + 1);

   if (WINDOW_CYC < 1) begin : g_bad_window
      $error("WINDOW_CYC must be at least 1");
   end
   if (KEY_A == KEY_B) begin : g_bad_keys
      $error("unlock keys must differ");
   end

   logic unl_wr, armed_q, open_load;

   assign unl_wr    = sfr_wr && (sfr_addr == UNLOCK_ADDR);
   assign open_load = unl_wr && armed_q && (sfr_wdata == KEY_B);

   always_ff @(posedge clk) begin
      if (!rst_n)      armed_q <= 1'b0;
      else if (sfr_wr) armed_q <= unl_wr && (sfr_wdata == KEY_A);
   end

   if (WINDOW_CYC == 1) begin : g_flag
      logic win_q;
      always_ff @(posedge clk) begin
         if (!rst_n) win_q <= 1'b0;
         else        win_q <= open_load;
      end
      assign win_open = win_q;
   end else begin : g_cnt
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                    cnt_q <= '0;
         else if (open_load)            cnt_q <= CNT_W'(WINDOW_CYC);
         else if (prot_hit && win_open) cnt_q <= '0;
         else if (cnt_q != '0)          cnt_q <= cnt_q - 1'b1;
      end
      assign win_open = (cnt_q != '0);
   end

   assert_single_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_hit && win_open && !open_load) |=> !win_open);

   assert_open_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(win_open) |-> $past(unl_wr));

endmodule

// File: rtl/acu_ctl_reg.sv
`timescale 1ns/1ps
module acu_ctl_reg
   import addr_ctl_pkg::*;
#(
   parameter int               SFR_AW    = 8,
   parameter logic [SFR_AW-1:0] CTL_ADDR  = 8'h9D,
   parameter logic [CTL_W-1:0] RST_VAL   = 8'hC0,
   parameter logic [CTL_W-1:0] RSV_MASK  = 8'hC0,
   parameter logic [CTL_W-1:0] KEEP_MASK = 8'h08
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              warm_n,
   input  logic              sfr_wr,
   input  logic [SFR_AW-1:0] sfr_addr,
   input  logic [CTL_W-1:0]  sfr_wdata,
   input  logic              win_open,
   input  logic              ea_pin,
   output logic [CTL_W-1:0]  ctl_q,
   output logic              prot_hit,
   output logic              self_rst_req,
   output logic              boot_internal
);
   if ((RSV_MASK & KEEP_MASK) != '0) begin : g_bad_masks
      $error("reserved and warm-kept bits overlap");
   end
   if ((RST_VAL & RSV_MASK) != RSV_MASK) begin : g_bad_rst
      $error("reset value must set all reserved bits");
   end

   logic wr_ok;
   assign prot_hit = sfr_wr && (sfr_addr == CTL_ADDR);
   assign wr_ok    = prot_hit && win_open;

   always_ff @(posedge clk) begin
      if (!por_n)       ctl_q <= RST_VAL;
      else if (!warm_n) ctl_q <= (RST_VAL & ~KEEP_MASK) | (ctl_q & KEEP_MASK);
      else if (wr_ok)   ctl_q <= (sfr_wdata & ~RSV_MASK) | RSV_MASK;
   end

   always_ff @(posedge clk) begin
      if (!por_n || !warm_n) self_rst_req <= 1'b0;
      else self_rst_req <= wr_ok && ea_pin && !ctl_q[BIT_BOOT] && sfr_wdata[BIT_BOOT];
   end

   always_ff @(posedge clk) begin
      if (!por_n)       boot_internal <= ea_pin;
      else if (!warm_n) boot_internal <= ea_pin && !ctl_q[BIT_BOOT];
   end

   assert_wr_gated_R2: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
      ($past(por_n && warm_n) && (ctl_q != $past(ctl_q))) |-> $past(wr_ok));

   assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
      self_rst_req |=> !self_rst_req);

   assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
      self_rst_req |-> (ctl_q[BIT_BOOT] && $past(ea_pin)));

   assert_boot_hold_R7: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
      $past(por_n && warm_n) |-> $stable(boot_internal));

endmodule

// File: rtl/acu_addr_map.sv
`timescale 1ns/1ps
module acu_addr_map
   import addr_ctl_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int BLK_W  = 15,
   parameter int SP_W   = 8,
   parameter int XSP_W  = 2,
   localparam int PG_W  = ADDR_W - 16,
   localparam int STK_W = SP_W + XSP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rom_alt,
   input  logic              stk_ext,
   input  amode_e            amode,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic [SP_W-1:0]   sp,
   input  logic [XSP_W-1:0]  esp_lo,
   input  logic [PG_W-1:0]   ap,
   input  logic              page_load,
   output logic              rom_lo_sel,
   output logic              rom_hi_sel,
   output logic [STK_W-1:0]  stack_addr,
   output logic [PG_W-1:0]   pc_hi
);
   if (ADDR_W <= 16) begin : g_bad_addr
      $error("ADDR_W must exceed 16");
   end
   if (BLK_W + 2 > ADDR_W) begin : g_bad_blk
      $error("BLK_W too large for ADDR_W");
   end
   if (XSP_W < 1) begin : g_bad_xsp
      $error("XSP_W must be at least 1");
   end

   localparam logic [ADDR_W-1:0] HI_BASE  = {ADDR_W{1'b1}} << BLK_W;
   localparam logic [ADDR_W-1:0] ALT_BASE = HI_BASE - (ADDR_W'(1) << BLK_W);

   function automatic logic in_blk(input logic [ADDR_W-1:0] a,
                                   input logic [ADDR_W-1:0] base);
      logic [ADDR_W-1:0] off;
      off = a - base;
      return (off >> BLK_W) == '0;
   endfunction

   always_comb begin
      rom_hi_sel = in_blk(fetch_addr, HI_BASE);
      rom_lo_sel = rom_alt ? in_blk(fetch_addr, ALT_BASE)
                           : in_blk(fetch_addr, '0);
   end

   assign stack_addr = stk_ext ? {esp_lo, sp} : {{XSP_W{1'b0}}, sp};

   logic [PG_W-1:0] pc_hi_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                                 pc_hi_q <= '0;
      else if (amode == AMODE_16)                 pc_hi_q <= '0;
      else if (amode == AMODE_PAGED && page_load) pc_hi_q <= ap;
   end
   assign pc_hi = (amode == AMODE_16) ? '0 : pc_hi_q;

   assert_pchi_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(amode == AMODE_16) |-> (pc_hi_q == '0));

   assert_pchi_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(amode == AMODE_CONTIG) |-> $stable(pc_hi_q));

   assert_stack_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stack_addr[STK_W-1:SP_W] != '0) |-> stk_ext);

endmodule

// File: rtl/addr_ctl_unit.sv
`timescale 1ns/1ps
module addr_ctl_unit
   import addr_ctl_pkg::*;
#(
   parameter int          ADDR_W      = 24,
   parameter int          BLK_W       = 15,
   parameter int          SP_W        = 8,
   parameter int          XSP_W       = 2,
   parameter int          SFR_AW      = 8,
   parameter logic [7:0]  CTL_ADDR    = 8'h9D,
   parameter logic [7:0]  UNLOCK_ADDR = 8'hC7,
   parameter int          WINDOW_CYC  = 3,
   localparam int         PG_W        = ADDR_W - 16,
   localparam int         STK_W       = SP_W + XSP_W
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              warm_rst_n,
   input  logic [SFR_AW-1:0] sfr_addr,
   input  logic              sfr_wr,
   input  logic [CTL_W-1:0]  sfr_wdata,
   output logic [CTL_W-1:0]  sfr_rdata,
   input  logic              ea_pin,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic [SP_W-1:0]   sp,
   input  logic [XSP_W-1:0]  esp_lo,
   input  logic [PG_W-1:0]   ap,
   input  logic              page_load,
   output logic              rom_lo_sel,
   output logic              rom_hi_sel,
   output logic              boot_internal,
   output logic [STK_W-1:0]  stack_addr,
   output logic [1:0]        addr_mode,
   output logic [PG_W-1:0]   pc_hi,
   output logic              bkpt_en,
   output logic              self_rst_req
);
   if (CTL_ADDR == UNLOCK_ADDR) begin : g_bad_sfr
      $error("control and unlock addresses must differ");
   end

   logic             rst_n, win_open, prot_hit;
   logic [CTL_W-1:0] ctl_q;
   amode_e           amode;

   assign rst_n = por_n && warm_rst_n;

   acu_timed_gate #(
      .SFR_AW(SFR_AW), .UNLOCK_ADDR(UNLOCK_ADDR), .WINDOW_CYC(WINDOW_CYC)
   ) gate_i (
      .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
      .sfr_wdata(sfr_wdata), .prot_hit(prot_hit), .win_open(win_open)
   );

   acu_ctl_reg #(
      .SFR_AW(SFR_AW), .CTL_ADDR(CTL_ADDR)
   ) reg_i (
      .clk(clk), .por_n(por_n), .warm_n(warm_rst_n), .sfr_wr(sfr_wr),
      .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .win_open(win_open),
      .ea_pin(ea_pin), .ctl_q(ctl_q), .prot_hit(prot_hit),
      .self_rst_req(self_rst_req), .boot_internal(boot_internal)
   );

   assign amode     = decode_amode(ctl_q[1:0]);
   assign addr_mode = amode;
   assign bkpt_en   = ctl_q[BIT_BKPT];
   assign sfr_rdata = (sfr_addr == CTL_ADDR) ? ctl_q : '0;

   acu_addr_map #(
      .ADDR_W(ADDR_W), .BLK_W(BLK_W), .SP_W(SP_W), .XSP_W(XSP_W)
   ) map_i (
      .clk(clk), .rst_n(rst_n), .rom_alt(ctl_q[BIT_ROM_ALT]),
      .stk_ext(ctl_q[BIT_STK]), .amode(amode), .fetch_addr(fetch_addr),
      .sp(sp), .esp_lo(esp_lo), .ap(ap), .page_load(page_load),
      .rom_lo_sel(rom_lo_sel), .rom_hi_sel(rom_hi_sel),
      .stack_addr(stack_addr), .pc_hi(pc_hi)
   );

   assert_bkpt_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(bkpt_en) |-> $past(sfr_wr && win_open));

endmodule

// File: tb/addr_ctl_unit_tb_top.sv
`timescale 1ns/1ps
module addr_ctl_unit_tb_top;
   localparam logic [7:0] CTL = 8'h9D;
   localparam logic [7:0] UNL = 8'hC7;

   logic        clk = 1'b0;
   logic        por_n = 1'b0, warm_rst_n = 1'b1;
   logic [7:0]  sfr_addr = 8'h00, sfr_wdata = 8'h00;
   logic        sfr_wr = 1'b0, ea_pin = 1'b1, page_load = 1'b0;
   logic [23:0] fetch_addr = 24'h0;
   logic [7:0]  sp = 8'h00, ap = 8'h00;
   logic [1:0]  esp_lo = 2'b00;
   logic [7:0]  sfr_rdata, pc_hi;
   logic        rom_lo_sel, rom_hi_sel, boot_internal, bkpt_en, self_rst_req;
   logic [9:0]  stack_addr;
   logic [1:0]  addr_mode;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   logic [7:0] exp_reg;
   logic [7:0] exp_pchi;
   logic [23:0] probes [0:8];

   always #5 clk = ~clk;

   addr_ctl_unit dut_i (
      .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .sfr_addr(sfr_addr),
      .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
      .ea_pin(ea_pin), .fetch_addr(fetch_addr), .sp(sp), .esp_lo(esp_lo),
      .ap(ap), .page_load(page_load), .rom_lo_sel(rom_lo_sel),
      .rom_hi_sel(rom_hi_sel), .boot_internal(boot_internal),
      .stack_addr(stack_addr), .addr_mode(addr_mode), .pc_hi(pc_hi),
      .bkpt_en(bkpt_en), .self_rst_req(self_rst_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
      sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
      @(negedge clk);
      sfr_wr = 1'b0;
   endtask

   task automatic unlock();
      sfr_write(UNL, 8'hAA);
      sfr_write(UNL, 8'h55);
   endtask

   task automatic prot_write(input logic [7:0] d);
      unlock();
      sfr_write(CTL, d);
   endtask

   task automatic rd_chk(input string req, input logic [7:0] exp);
      sfr_addr = CTL; #1;
      chk(req, sfr_rdata, exp);
   endtask

   task automatic do_reset(input bit power_on);
      if (power_on) por_n = 1'b0; else warm_rst_n = 1'b0;
      repeat (3) @(negedge clk);
      por_n = 1'b1; warm_rst_n = 1'b1;
   endtask

   function automatic logic exp_lo(input logic [23:0] a, input logic alt);
      return alt ? (a >= 24'hFF0000 && a <= 24'hFF7FFF) : (a <= 24'h007FFF);
   endfunction

   function automatic logic [1:0] exp_mode(input logic [1:0] f);
      return f[1] ? 2'd2 : (f[0] ? 2'd1 : 2'd0);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      probes[0] = 24'h000000; probes[1] = 24'h007FFF; probes[2] = 24'h008000;
      probes[3] = 24'hFEFFFF; probes[4] = 24'hFF0000; probes[5] = 24'hFF7FFF;
      probes[6] = 24'hFF8000; probes[7] = 24'hFFFFFF; probes[8] = 24'h123456;

      // power-on reset with pin high
      ea_pin = 1'b1;
      do_reset(1'b1);
      #1;
      rd_chk("R3 por value", 8'hC0);
      chk("R7 por boot", boot_internal, 1);
      chk("R6 reset bkpt", bkpt_en, 0);
      chk("R10 reset mode", addr_mode, 0);
      chk("R11 reset pc_hi", pc_hi, 0);
      chk("R8 reset pulse", self_rst_req, 0);
      sfr_addr = 8'h80; #1;
      chk("R1 other address reads zero", sfr_rdata, 0);
      exp_reg = 8'hC0;

      // R2 window-edge sweep
      @(negedge clk);
      for (int k = 0; k <= 4; k++) begin
         unlock();
         repeat (k) @(negedge clk);
         sfr_write(CTL, 8'h01 + 8'(k));
         if (k <= 2) exp_reg = 8'hC0 | (8'h01 + 8'(k));
         rd_chk("R2 window gap", exp_reg);
         chk("R8 no pulse in gap sweep", self_rst_req, 0);
      end
      sfr_write(CTL, 8'h06);
      rd_chk("R2 write without unlock", exp_reg);
      sfr_write(UNL, 8'hAA); sfr_write(8'h80, 8'h00); sfr_write(UNL, 8'h55);
      sfr_write(CTL, 8'h06);
      rd_chk("R2 broken key sequence", exp_reg);
      sfr_write(UNL, 8'h55); sfr_write(CTL, 8'h06);
      rd_chk("R2 second key alone", exp_reg);
      unlock(); sfr_write(CTL, 8'h06); sfr_write(CTL, 8'h07);
      exp_reg = 8'hC6;
      rd_chk("R2 one write per window", exp_reg);

      // exhaustive sweep of writable bits with pin low
      ea_pin = 1'b0;
      exp_pchi = 8'h00;
      for (int v = 0; v < 64; v++) begin
         logic [1:0] old_mode, new_mode;
         old_mode = exp_mode(exp_reg[1:0]);
         prot_write(8'(v));
         exp_reg = 8'hC0 | 8'(v);
         new_mode = exp_mode(exp_reg[1:0]);
         rd_chk("R1 read after write", exp_reg);
         chk("R6 bkpt flag", bkpt_en, exp_reg[4]);
         chk("R10 mode code", addr_mode, new_mode);
         chk("R8 no pulse with pin low", self_rst_req, 0);
         sp = 8'(v * 7 + 3); esp_lo = 2'(v ^ 2); #1;
         chk("R9 stack address", stack_addr,
             exp_reg[2] ? {esp_lo, sp} : {2'b00, sp});
         if (old_mode == 2'd0) exp_pchi = 8'h00;
         ap = 8'h30 + 8'(v);
         page_load = 1'b1;
         @(negedge clk);
         page_load = 1'b0;
         if (new_mode == 2'd0)      exp_pchi = 8'h00;
         else if (new_mode == 2'd1) exp_pchi = ap;
         #1;
         chk("R11 high pc byte", pc_hi, (new_mode == 2'd0) ? 8'h00 : exp_pchi);
         for (int p = 0; p < 9; p++) begin
            fetch_addr = probes[p]; #1;
            chk("R4 lower rom select", rom_lo_sel, exp_lo(probes[p], exp_reg[5]));
            chk("R5 upper rom select", rom_hi_sel, probes[p] >= 24'hFF8000);
         end
      end
      rd_chk("R3 reserved bits read one", 8'hFF);

      // self-reset and boot capture
      ea_pin = 1'b1;
      @(negedge clk);
      prot_write(8'h08); #1;
      chk("R8 no pulse when bit already set", self_rst_req, 0);
      prot_write(8'h00); #1;
      chk("R8 no pulse on clear", self_rst_req, 0);
      chk("R7 clear has no effect before reset", boot_internal, 1);
      prot_write(8'h08); #1;
      chk("R8 pulse on set", self_rst_req, 1);
      @(negedge clk); #1;
      chk("R8 pulse one cycle", self_rst_req, 0);
      prot_write(8'h3F); #1;
      chk("R8 no pulse bit kept", self_rst_req, 0);
      do_reset(1'b0); #1;
      rd_chk("R3 warm keeps bit3", 8'hC8);
      chk("R7 warm capture with bit3 set", boot_internal, 0);
      prot_write(8'h00); #1;
      chk("R7 boot unchanged by write", boot_internal, 0);
      do_reset(1'b0); #1;
      rd_chk("R3 warm with bit3 clear", 8'hC0);
      chk("R7 warm capture with bit3 clear", boot_internal, 1);
      ea_pin = 1'b0;
      prot_write(8'h08); #1;
      chk("R8 no pulse with pin low", self_rst_req, 0);
      do_reset(1'b1); #1;
      rd_chk("R3 por clears bit3", 8'hC0);
      chk("R7 por capture pin low", boot_internal, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule